// File: doc/BRIEF.md
# GPIO Pin Interrupt and Synchronizer Controller

This block holds the per-pin logic of a general-purpose I/O controller. The pad input passes through two synchronizer stages in series. Each stage can be bypassed, or set to capture on the falling or on the rising clock edge. The result feeds a trigger detector. That detector either latches edges into a sticky status bit or reports a selected level while that level is present. The pending condition can be sent to a maskable CPU interrupt line, to a non-maskable CPU interrupt line, or to both. The same pin can drive its output as push-pull or can emulate open-drain through its output enable. While the system is in light sleep, a present level condition can also raise a wakeup request.

Software sees four word registers through a simple write strobe with address and data, and through a combinational read port. The registers are configuration at address 0, status at address 1 (write 1 to clear), output data at address 2 and the synchronized input at address 3 (read only). All registers reset to zero.

Top module: `gpio_pin_ctl`

## Requirements
- R1: While reset is asserted, both interrupt outputs and the wakeup output are 0, pad_oe is 1, pad_out is 0, and every register reads 0.
- R2: The trigger code is configuration bits [2:0]. Codes 1, 2 and 3 latch a rising, a falling or any change of the synchronized input. The change is found by comparing the input with its value one clock earlier. The status reads 1 (status bit 0) from the clock edge at which the change is seen until software clears it.
- R3: Code 4 makes the status read 1 while the synchronized input is 0. Code 5 makes it read 1 while the input is 1. Neither level code latches anything.
- R4: Codes 0, 6 and 7 give status 0 and no interrupt, whatever the input does.
- R5: Configuration bit 13 passes the status to irq_cpu, and bit 14 passes it to irq_nmi. Each bit works on its own.
- R6: Writing address 1 with bit 0 set clears the latched edge status. Writing it with bit 0 clear has no effect. A new edge seen in the same cycle as the clear leaves the status at 1.
- R7: With configuration bit 3 set (open-drain), pad_out is 0 and pad_oe is the inverse of the output data bit.
- R8: With configuration bit 3 clear, pad_oe is 1 and pad_out equals the output data bit (address 2, bit 0).
- R9: Bits [5:4] set the first synchronizer stage and bits [7:6] set the second, which takes the first stage's output. Mode 0 passes the input through, 1 captures it on the falling clock edge, and 2 or 3 capture it on the rising edge. Address 3 bit 0 reads the output of the second stage.
- R10: wake_req is 1 exactly when configuration bit 8 is set, sleep_light is 1 and a level code (R3) currently matches.
- R11: Configuration writes keep bits [8:0], 13 and 14 and read back 0 in all other positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr |
| pad_in | input | 1 | Pad input level |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |
| irq_cpu | output | 1 | Maskable interrupt request |
| irq_nmi | output | 1 | Non-maskable interrupt request |
| sleep_light | input | 1 | System is in light sleep |
| wake_req | output | 1 | Wakeup request |

## Verification
The hardest case to reach is a falling-edge synchronizer stage. Its output changes half a cycle after a rising-edge sample, so a single pad pulse can show a different delay depending on the mode mix, and the edge it produces can land in the same cycle as a status clear. The stimulus steps through stage mode pairs with short pad pulses. It also compares the outputs after both the rising and the falling clock edge, so the half-cycle state is visible. A separate sequence lines up a pad change with a clear write in the same cycle.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

   localparam int CFG_W      = 15;
   localparam int NUM_STAGES = 2;

   localparam int A_CFG  = 0;
   localparam int A_STAT = 1;
   localparam int A_DOUT = 2;
   localparam int A_DIN  = 3;

   typedef enum logic [2:0] {
      TRIG_OFF  = 3'd0,
      TRIG_RISE = 3'd1,
      TRIG_FALL = 3'd2,
      TRIG_BOTH = 3'd3,
      TRIG_LOW  = 3'd4,
      TRIG_HIGH = 3'd5,
      TRIG_RSV6 = 3'd6,
      TRIG_RSV7 = 3'd7
   } trig_e;

   typedef enum logic [1:0] {
      STG_BYPASS   = 2'd0,
      STG_FALL     = 2'd1,
      STG_RISE     = 2'd2,
      STG_RISE_ALT = 2'd3
   } stg_e;

   typedef struct packed {
      logic       nmi_en;   // 14
      logic       cpu_en;   // 13
      logic [3:0] rsvd_b;   // 12:9
      logic       wake_en;  // 8
      stg_e       stg2;     // 7:6
      stg_e       stg1;     // 5:4
      logic       od_sel;   // 3
      trig_e      trig;     // 2:0
   } cfg_t;

   localparam logic [CFG_W-1:0] CFG_WMASK = 15'h61FF;

endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage
   import gpio_pin_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  stg_e mode,
   input  logic d,
   output logic q
);

   logic q_rise;
   logic q_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_rise <= 1'b0;
      else        q_rise <= d;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) q_fall <= 1'b0;
      else        q_fall <= d;
   end

   always_comb begin
      unique case (mode)
         STG_BYPASS: q = d;
         STG_FALL:   q = q_fall;
         default:    q = q_rise;
      endcase
   end

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
   import gpio_pin_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  trig_e trig,
   input  logic  s,
   input  logic  clr,
   output logic  pend,
   output logic  lvl_hit
);

   logic prev_q;
   logic sticky_q;
   logic is_edge;
   logic edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= s;
   end

   always_comb begin
      is_edge  = 1'b0;
      edge_hit = 1'b0;
      lvl_hit  = 1'b0;
      unique case (trig)
         TRIG_RISE: begin is_edge = 1'b1; edge_hit = s & ~prev_q; end
         TRIG_FALL: begin is_edge = 1'b1; edge_hit = ~s & prev_q; end
         TRIG_BOTH: begin is_edge = 1'b1; edge_hit = s ^ prev_q;  end
         TRIG_LOW:  lvl_hit = ~s;
         TRIG_HIGH: lvl_hit = s;
         default:   ;
      endcase
   end

   // a set in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sticky_q <= 1'b0;
      else if (edge_hit) sticky_q <= 1'b1;
      else if (clr)      sticky_q <= 1'b0;
   end

   assign pend = is_edge ? sticky_q : lvl_hit;

   a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q && !clr) |=> sticky_q);

   a_r2_any_change_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (trig == TRIG_BOTH && s != prev_q) |=> sticky_q);

   a_r3_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (trig == TRIG_HIGH) |-> (pend == s));

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
   import gpio_pin_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              pad_in,
   output logic              pad_out,
   output logic              pad_oe,
   output logic              irq_cpu,
   output logic              irq_nmi,
   input  logic              sleep_light,
   output logic              wake_req
);

   localparam logic [ADDR_W-1:0] AD_CFG  = ADDR_W'(A_CFG);
   localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] AD_DOUT = ADDR_W'(A_DOUT);
   localparam logic [ADDR_W-1:0] AD_DIN  = ADDR_W'(A_DIN);

   generate
      if (REG_W <= CFG_W) begin : g_bad_reg_w
         $error("REG_W must exceed the configuration width");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   cfg_t cfg_q;
   logic dout_q;
   logic clr_stat;
   logic pend;
   logic lvl_hit;
   logic sync_in;
   logic unused_bits;

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         dout_q <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == AD_CFG)  cfg_q  <= cfg_t'(reg_wdata[CFG_W-1:0] & CFG_WMASK);
         if (reg_addr == AD_DOUT) dout_q <= reg_wdata[0];
      end
   end

   assign clr_stat    = reg_wr && (reg_addr == AD_STAT) && reg_wdata[0];
   assign unused_bits = ^{reg_wdata[REG_W-1:CFG_W], cfg_q.rsvd_b};

   // cascaded synchronizer stages
   logic [NUM_STAGES:0]  chain;
   stg_e                 stg_mode [NUM_STAGES];

   assign stg_mode[0] = cfg_q.stg1;
   assign stg_mode[1] = cfg_q.stg2;
   assign chain[0]    = pad_in;

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         gpio_sync_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (stg_mode[i]),
            .d     (chain[i]),
            .q     (chain[i+1])
         );
      end
   endgenerate

   assign sync_in = chain[NUM_STAGES];

   gpio_trig_detect u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (cfg_q.trig),
      .s       (sync_in),
      .clr     (clr_stat),
      .pend    (pend),
      .lvl_hit (lvl_hit)
   );

   assign irq_cpu  = pend & cfg_q.cpu_en;
   assign irq_nmi  = pend & cfg_q.nmi_en;
   assign wake_req = cfg_q.wake_en & sleep_light & lvl_hit;

   // output driver
   always_comb begin
      if (cfg_q.od_sel) begin
         pad_out = 1'b0;
         pad_oe  = ~dout_q;
      end else begin
         pad_out = dout_q;
         pad_oe  = 1'b1;
      end
   end

   // read port
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         AD_CFG:  reg_rdata[CFG_W-1:0] = cfg_q;
         AD_STAT: reg_rdata[0] = pend;
         AD_DOUT: reg_rdata[0] = dout_q;
         AD_DIN:  reg_rdata[0] = sync_in;
         default: ;
      endcase
   end

   a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (sleep_light && cfg_q.wake_en));

   a_r5_nmi_routed: assert property (@(posedge clk) disable iff (!rst_n)
      irq_nmi |-> cfg_q.nmi_en);

   a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.trig inside {TRIG_OFF, TRIG_RSV6, TRIG_RSV7}) |-> (!irq_cpu && !irq_nmi));

   a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.od_sel && pad_oe) |-> !pad_out);

   a_r8_pp_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.od_sel |-> pad_oe);

endmodule

// File: tb/gpio_pin_ctl_test.sv
module gpio_pin_ctl_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pad_in = 1'b0;
   logic        pad_out, pad_oe, irq_cpu, irq_nmi, wake_req;
   logic        sleep_light = 1'b0;

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   gpio_pin_ctl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq_cpu(irq_cpu), .irq_nmi(irq_nmi),
      .sleep_light(sleep_light), .wake_req(wake_req)
   );

   always #(CLK_P/2) clk = ~clk;

   // behavioural reference state
   logic [14:0] m_cfg = '0;
   logic m_dout = 0, m_sticky = 0, m_prev = 0;
   logic s1p = 0, s1n = 0, s2p = 0, s2n = 0;

   function automatic logic stage_val(input logic [1:0] md, input logic d,
                                      input logic fq, input logic rq);
      if (md == 2'd0) return d;
      if (md == 2'd1) return fq;
      return rq;
   endfunction

   function automatic logic ref_sync();
      logic a;
      a = stage_val(m_cfg[5:4], pad_in, s1n, s1p);
      return stage_val(m_cfg[7:6], a, s2n, s2p);
   endfunction

   always @(posedge clk) begin
      logic o1, o2, ev;
      int t;
      if (rst_n) begin
         o1 = stage_val(m_cfg[5:4], pad_in, s1n, s1p);
         o2 = stage_val(m_cfg[7:6], o1, s2n, s2p);
         t  = int'(m_cfg[2:0]);
         ev = (t == 1 && o2 && !m_prev) || (t == 2 && !o2 && m_prev) ||
              (t == 3 && o2 != m_prev);
         if (ev) m_sticky = 1'b1;
         else if (reg_wr && reg_addr == 2'd1 && reg_wdata[0]) m_sticky = 1'b0;
         m_prev = o2;
         s1p = pad_in;
         s2p = o1;
         if (reg_wr && reg_addr == 2'd0) m_cfg = reg_wdata[14:0] & 15'h61FF;
         if (reg_wr && reg_addr == 2'd2) m_dout = reg_wdata[0];
      end
   end

   always @(negedge clk) begin
      logic o1;
      if (rst_n) begin
         o1  = stage_val(m_cfg[5:4], pad_in, s1n, s1p);
         s2n = o1;
         s1n = pad_in;
      end
   end

   task automatic check1(input string nm, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, nm, act, exp, $time);
      end
   endtask

   task automatic check_all();
      logic o2, lvl, pend;
      int t;
      o2   = ref_sync();
      t    = int'(m_cfg[2:0]);
      lvl  = (t == 4 && !o2) || (t == 5 && o2);
      pend = (t >= 1 && t <= 3) ? m_sticky : lvl;
      check1("irq_cpu", {31'd0, irq_cpu}, {31'd0, pend & m_cfg[13]});
      check1("irq_nmi", {31'd0, irq_nmi}, {31'd0, pend & m_cfg[14]});
      check1("wake_req", {31'd0, wake_req}, {31'd0, m_cfg[8] & sleep_light & lvl});
      check1("pad_out", {31'd0, pad_out}, {31'd0, m_cfg[3] ? 1'b0 : m_dout});
      check1("pad_oe", {31'd0, pad_oe}, {31'd0, m_cfg[3] ? ~m_dout : 1'b1});
      case (reg_addr)
         2'd0: check1("rdata_cfg", reg_rdata, {17'd0, m_cfg});
         2'd1: check1("rdata_stat", reg_rdata, {31'd0, pend});
         2'd2: check1("rdata_dout", reg_rdata, {31'd0, m_dout});
         default: check1("rdata_din", reg_rdata, {31'd0, o2});
      endcase
   endtask

   always begin
      @(posedge clk); #4;
      if (rst_n) check_all();
      @(negedge clk); #4;
      if (rst_n) check_all();
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc(1);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse_train(input int n);
      for (int i = 0; i < n; i++) begin
         pad_in = ~pad_in;
         cyc(1 + (i % 3));
      end
   endtask

   task automatic read_rot(input int n);
      for (int i = 0; i < n; i++) begin
         reg_addr = 2'(i);
         pad_in = (i % 2 == 1) ? ~pad_in : pad_in;
         cyc(1);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      // R1: reset state
      #3;
      cur_req = "R1";
      check_all();
      for (int a = 0; a < 4; a++) begin
         reg_addr = 2'(a); #0.1;
         check1("rdata_reset", reg_rdata, 32'd0);
      end
      reg_addr = 2'd0;
      #14 rst_n = 1'b1;
      cyc(1);

      // R8: push-pull data
      cur_req = "R8";
      wr(2'd2, 32'h1); reg_addr = 2'd2; cyc(2);
      wr(2'd2, 32'h0); cyc(2);

      // R11: writable bits only
      cur_req = "R11";
      wr(2'd0, 32'hFFFF_FFF8); reg_addr = 2'd0; cyc(2);
      wr(2'd0, 32'h0); cyc(1);

      // R2 R5: rising with cpu line, then clear (R6)
      cur_req = "R2 R5 rise";
      wr(2'd0, 32'h2001); reg_addr = 2'd1;
      pad_in = 1'b1; cyc(3); pad_in = 1'b0; cyc(2);
      cur_req = "R6 clear";
      wr(2'd1, 32'h0); cyc(2);
      wr(2'd1, 32'h1); cyc(2);
      cur_req = "R2 R5 fall nmi";
      wr(2'd0, 32'h4002); reg_addr = 2'd1;
      pulse_train(6);
      wr(2'd1, 32'h1); cyc(1);
      cur_req = "R2 R5 both";
      wr(2'd0, 32'h6003); reg_addr = 2'd1;
      pulse_train(5);
      wr(2'd1, 32'h1); pulse_train(3);

      // R6: edge coincides with clear
      cur_req = "R6 set wins";
      wr(2'd0, 32'h2001); wr(2'd1, 32'h1); pad_in = 1'b0; cyc(2);
      reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1; pad_in = 1'b1;
      cyc(1); reg_wr = 1'b0; cyc(2);

      // R9: stage mode combinations
      for (int m = 0; m < 16; m++) begin
         cur_req = $sformatf("R9 stg1=%0d stg2=%0d", m % 4, m / 4);
         wr(2'd0, 32'h6003 | (32'(m) << 4));
         wr(2'd1, 32'h1);
         reg_addr = 2'(3 - (m % 2) * 2);
         pulse_train(7);
         pad_in = ~pad_in; cyc(1); pad_in = ~pad_in; cyc(4);
      end

      // R3 R10: level modes with wakeup
      cur_req = "R3 R10 low";
      wr(2'd0, 32'h6104); reg_addr = 2'd1;
      sleep_light = 1'b1; pulse_train(5); sleep_light = 1'b0; pulse_train(4);
      cur_req = "R3 R10 high";
      wr(2'd0, 32'h2155); sleep_light = 1'b1; reg_addr = 2'd1;
      pulse_train(6);
      cur_req = "R10 disabled";
      wr(2'd0, 32'h2005); pulse_train(4); sleep_light = 1'b0;

      // R4: disabled codes
      for (int c = 0; c < 3; c++) begin
         cur_req = $sformatf("R4 code %0d", (c == 0) ? 0 : c + 5);
         wr(2'd0, 32'h6100 | ((c == 0) ? 32'd0 : 32'(c + 5)));
         sleep_light = 1'b1; reg_addr = 2'd1;
         pulse_train(6);
         sleep_light = 1'b0;
      end

      // R7: open drain
      cur_req = "R7";
      wr(2'd0, 32'h8); reg_addr = 2'd2;
      wr(2'd2, 32'h1); cyc(2); wr(2'd2, 32'h0); cyc(2); wr(2'd2, 32'h1); cyc(1);
      cur_req = "R8 return";
      wr(2'd0, 32'h0); cyc(2);

      cur_req = "R9 readback";
      wr(2'd0, 32'h00A3); read_rot(12);

      cyc(3);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule